// File: doc/BRIEF.md
# Flash Command and Write-Sequencer Controller

This block is the command front end and timed write sequencer of a byte-writable flash array of 32 blocks. A host issues command cycles on a simple write strobe. Some commands take effect at once: choosing array or status reads, and clearing the error flags. Others open a two-cycle sequence that starts a timed operation: a byte program, a block erase, or a change to the protection bits. Each timed operation holds the ready output low for a fixed number of clock cycles, set by a parameter. When it ends, the array or the protection bits are updated and the ready output rises again.

Protection has two levels. Each block has a lock bit, and a locked block refuses programming and erasure. A master lock bit, once set, refuses every change to the block lock bits. A refused operation ends at once, sets a sticky protection flag and leaves the array untouched. An erase can be paused so that the host can read, or program, other blocks. A byte program can be paused so that the host can read other locations. Both resume with the confirm code. Pulling the power-down input low aborts any operation, clears the status and ignores all commands. The array contents and the lock bits are kept.

The array is a block-RAM style register file with one registered read port and one write port. An erase writes 0xFF to the block's bytes, one byte per cycle, during the last cycles of its timed window.

Top module: `flash_wsm`

## Requirements
- R1: Command 0x40 followed by a data cycle (address, byte) stores the byte at that address. The ready output is low for exactly WR_CYC sampled cycles, starting one cycle after the data cycle.
- R2: Command 0x20 followed by 0xD0 on an address inside a block sets every byte of that block to 0xFF. The ready output is low for exactly ER_CYC cycles of active erasing.
- R3: After command 0x60 then 0x01 on an address in a block, that block's lock bit is set. Later programs or erases of that block are refused without the ready output going low. Status bit 4 (protection error) is set and the array is left unchanged.
- R4: Command 0x60 then 0xF1 sets the master lock bit. Once it is set, 0x60/0x01 and 0x60/0xD0 are refused with status bit 4 set, and the block lock bits keep their values.
- R5: Command 0x60 then 0xD0 clears all block lock bits while the master lock bit is clear.
- R6: Command 0xB0 during an erase suspends it. Ready goes high, and status bit 6 is set. Reads and byte programs of other blocks work. A program of the suspended block is refused with status bit 4. 0xD0 resumes the erase, which completes after its remaining active cycles.
- R7: Command 0xB0 during a byte program (no erase pending) suspends it. Ready goes high, and status bit 5 is set. The target byte keeps its old value until 0xD0 resumes the program, which finishes after its remaining cycles.
- R8: Command 0x70 selects status reads and 0xFF selects array reads. Starting or refusing a timed operation also selects status reads. A read returns data on bus_rdata one cycle after bus_rd. The status byte holds ready in bit 7; bits 2..0 are zero. Command 0x50 clears bits 4 and 3, and bit 4 stays set until then.
- R9: A setup command (0x20 or 0x60) followed by a code it does not accept sets status bit 3 (sequence error) and starts nothing.
- R10: While pd_n is low, the ready output is high from the next cycle and any running or suspended operation is aborted. Status reads 0x80 afterwards, and bus writes are ignored. Array contents and lock bits are preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the sequencer and lock bits |
| pd_n | input | 1 | Active-low power-down; resets the sequencer and status, ignores writes |
| bus_wr | input | 1 | Command or data write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears one cycle later |
| bus_addr | input | AW | Byte address (upper bits select the block) |
| bus_wdata | input | 8 | Command code or program data |
| bus_rdata | output | 8 | Array byte or status byte, per read mode |
| wsm_ready | output | 1 | High when idle, suspended or powered down; low while an operation runs |

## Verification
On every cycle, the assertions check four things. No array write ever lands in a locked block. The master lock bit never clears once set, and while it is set the block lock bits cannot move. The protection flag falls only after a clear-status write or during power-down. Ready is high in the cycle after power-down is seen. Exact busy durations need the bench's scenarios, and so do the resumed remainders after a suspend, the array contents after programs, erases and aborts, and the status byte seen through reads.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WSET, PH_ESET, PH_LSET} phase_t;
  typedef enum logic [1:0] {FG_WRITE, FG_LBLK, FG_LMST, FG_LCLR} fg_kind_t;

  localparam logic [7:0] C_WSETUP  = 8'h40;
  localparam logic [7:0] C_ESETUP  = 8'h20;
  localparam logic [7:0] C_LSETUP  = 8'h60;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_RSTAT   = 8'h70;
  localparam logic [7:0] C_RARRAY  = 8'hFF;
  localparam logic [7:0] C_CLRSTAT = 8'h50;
  localparam logic [7:0] C_LBLK    = 8'h01;
  localparam logic [7:0] C_LMST    = 8'hF1;
endpackage

// File: rtl/flash_wsm_array.sv
module flash_wsm_array #(
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_wsm_locks.sv
module flash_wsm_locks #(
  parameter int NBLK = 32,
  localparam int BKW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_blk,
  input  logic [BKW-1:0]  blk_idx,
  input  logic            set_mst,
  input  logic            clr_all,
  output logic [NBLK-1:0] blk_lock,
  output logic            mst_lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_lock <= '0;
      mst_lock <= 1'b0;
    end else begin
      if (clr_all) blk_lock <= '0;
      else if (set_blk) blk_lock[blk_idx] <= 1'b1;
      if (set_mst) mst_lock <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_wsm_ctrl.sv
module flash_wsm_ctrl
  import flash_wsm_pkg::*;
#(
  parameter int NBLK = 32,
  parameter int BLK_BYTES = 4,
  parameter int WR_CYC = 300,
  parameter int ER_CYC = 20000,
  parameter int LK_CYC = 150,
  localparam int BKW = $clog2(NBLK),
  localparam int BW = $clog2(BLK_BYTES),
  localparam int AW = BKW + BW,
  localparam int MAXWL = (WR_CYC > LK_CYC) ? WR_CYC : LK_CYC,
  localparam int MAXC = (ER_CYC > MAXWL) ? ER_CYC : MAXWL,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic [NBLK-1:0] blk_lock,
  input  logic            mst_lock,
  output logic            lk_set_blk,
  output logic [BKW-1:0]  lk_idx,
  output logic            lk_set_mst,
  output logic            lk_clr_all,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [7:0]      mem_wdata,
  output logic [7:0]      status,
  output logic            stat_mode,
  output logic            wsm_ready
);
  phase_t   phase;
  fg_kind_t fg_kind;
  logic            fg_act, fg_susp, er_act, er_susp, prot, seq;
  logic [CW-1:0]   fg_cnt, er_cnt;
  logic [AW-1:0]   fg_addr;
  logic [7:0]      fg_data;
  logic [BKW-1:0]  er_blk;

  logic [BKW-1:0] a_blk;
  logic running, fg_tick, er_tick, fg_done;

  assign a_blk   = bus_addr[AW-1:BW];
  assign fg_tick = fg_act & ~fg_susp;
  assign er_tick = er_act & ~er_susp & ~fg_act;
  assign running = fg_tick | (er_act & ~er_susp);
  assign fg_done = fg_tick && (fg_cnt == '0) && pd_n;

  assign mem_we = pd_n && ((fg_done && fg_kind == FG_WRITE) ||
                           (er_tick && er_cnt < CW'(BLK_BYTES)));
  assign mem_waddr  = fg_act ? fg_addr : {er_blk, er_cnt[BW-1:0]};
  assign mem_wdata  = fg_act ? fg_data : 8'hFF;
  assign lk_set_blk = fg_done && fg_kind == FG_LBLK;
  assign lk_set_mst = fg_done && fg_kind == FG_LMST;
  assign lk_clr_all = fg_done && fg_kind == FG_LCLR;
  assign lk_idx     = fg_addr[AW-1:BW];
  assign status     = {~running, er_susp, fg_susp, prot, seq, 3'b000};

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      phase <= PH_IDLE;
      fg_kind <= FG_WRITE;
      fg_act <= 1'b0; fg_susp <= 1'b0;
      er_act <= 1'b0; er_susp <= 1'b0;
      prot <= 1'b0;   seq <= 1'b0;
      fg_cnt <= '0;   er_cnt <= '0;
      fg_addr <= '0;  fg_data <= '0;  er_blk <= '0;
      stat_mode <= 1'b0;
      wsm_ready <= 1'b1;
    end else begin
      wsm_ready <= ~running;
      if (fg_tick) begin
        if (fg_cnt == '0) fg_act <= 1'b0;
        else fg_cnt <= fg_cnt - 1'b1;
      end
      if (er_tick) begin
        if (er_cnt == '0) er_act <= 1'b0;
        else er_cnt <= er_cnt - 1'b1;
      end
      if (bus_wr) begin
        case (phase)
          PH_WSET: begin
            phase <= PH_IDLE;
            stat_mode <= 1'b1;
            if (blk_lock[a_blk] || (er_act && a_blk == er_blk)) prot <= 1'b1;
            else begin
              fg_act <= 1'b1; fg_kind <= FG_WRITE;
              fg_cnt <= CW'(WR_CYC - 1);
              fg_addr <= bus_addr; fg_data <= bus_wdata;
            end
          end
          PH_ESET: begin
            phase <= PH_IDLE;
            stat_mode <= 1'b1;
            if (bus_wdata != C_CONFIRM) seq <= 1'b1;
            else if (blk_lock[a_blk]) prot <= 1'b1;
            else begin
              er_act <= 1'b1; er_blk <= a_blk;
              er_cnt <= CW'(ER_CYC - 1);
            end
          end
          PH_LSET: begin
            phase <= PH_IDLE;
            stat_mode <= 1'b1;
            fg_addr <= bus_addr;
            fg_cnt <= CW'(LK_CYC - 1);
            case (bus_wdata)
              C_LBLK: begin
                if (mst_lock) prot <= 1'b1;
                else begin fg_act <= 1'b1; fg_kind <= FG_LBLK; end
              end
              C_LMST: begin fg_act <= 1'b1; fg_kind <= FG_LMST; end
              C_CONFIRM: begin
                if (mst_lock) prot <= 1'b1;
                else begin fg_act <= 1'b1; fg_kind <= FG_LCLR; end
              end
              default: seq <= 1'b1;
            endcase
          end
          default: begin
            case (bus_wdata)
              C_RARRAY:  stat_mode <= 1'b0;
              C_RSTAT:   stat_mode <= 1'b1;
              C_CLRSTAT: begin prot <= 1'b0; seq <= 1'b0; end
              C_WSETUP:  if (!fg_act && (!er_act || er_susp)) phase <= PH_WSET;
              C_ESETUP:  if (!fg_act && !er_act) phase <= PH_ESET;
              C_LSETUP:  if (!fg_act && !er_act) phase <= PH_LSET;
              C_SUSPEND: begin
                if (fg_tick && fg_kind == FG_WRITE && !er_act && fg_cnt != '0)
                  fg_susp <= 1'b1;
                else if (er_tick && er_cnt != '0)
                  er_susp <= 1'b1;
              end
              C_CONFIRM: begin
                if (fg_susp) fg_susp <= 1'b0;
                else if (er_susp && !fg_act) er_susp <= 1'b0;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int NBLK = 32,
  parameter int BLK_BYTES = 4,
  parameter int WR_CYC = 300,
  parameter int ER_CYC = 20000,
  parameter int LK_CYC = 150,
  localparam int BKW = $clog2(NBLK),
  localparam int BW = $clog2(BLK_BYTES),
  localparam int AW = BKW + BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          wsm_ready
);
  logic [NBLK-1:0] blk_lock;
  logic            mst_lock, lk_set_blk, lk_set_mst, lk_clr_all;
  logic [BKW-1:0]  lk_idx;
  logic            mem_we, stat_mode;
  logic [AW-1:0]   mem_waddr;
  logic [7:0]      mem_wdata, mem_q, status, stat_q;
  logic            rd_stat_q;

  flash_wsm_ctrl #(
    .NBLK(NBLK), .BLK_BYTES(BLK_BYTES),
    .WR_CYC(WR_CYC), .ER_CYC(ER_CYC), .LK_CYC(LK_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pd_n(pd_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .blk_lock(blk_lock), .mst_lock(mst_lock),
    .lk_set_blk(lk_set_blk), .lk_idx(lk_idx),
    .lk_set_mst(lk_set_mst), .lk_clr_all(lk_clr_all),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .status(status), .stat_mode(stat_mode), .wsm_ready(wsm_ready)
  );

  flash_wsm_locks #(.NBLK(NBLK)) u_locks (
    .clk(clk), .rst(rst),
    .set_blk(lk_set_blk), .blk_idx(lk_idx),
    .set_mst(lk_set_mst), .clr_all(lk_clr_all),
    .blk_lock(blk_lock), .mst_lock(mst_lock)
  );

  flash_wsm_array #(.AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(bus_rd), .raddr(bus_addr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat_q <= 1'b0;
      stat_q <= '0;
    end else if (bus_rd) begin
      rd_stat_q <= stat_mode;
      stat_q <= status;
    end
  end

  assign bus_rdata = rd_stat_q ? stat_q : mem_q;
endmodule

// File: rtl/flash_wsm_chk.sv
module flash_wsm_chk #(
  parameter int NBLK = 32,
  parameter int BW = 2,
  parameter int AW = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            pd_n,
  input logic            bus_wr,
  input logic [7:0]      bus_wdata,
  input logic            wsm_ready,
  input logic [7:0]      status,
  input logic [NBLK-1:0] blk_lock,
  input logic            mst_lock,
  input logic            mem_we,
  input logic [AW-1:0]   mem_waddr
);
  p_no_locked_write_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !blk_lock[mem_waddr[AW-1:BW]]);

  p_master_gate_r4: assert property (@(posedge clk) disable iff (rst)
    mst_lock |=> $stable(blk_lock));

  p_master_keep_r4: assert property (@(posedge clk) disable iff (rst)
    mst_lock |=> mst_lock);

  p_prot_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(status[4]) |-> $past((bus_wr && bus_wdata == 8'h50) || !pd_n));

  p_pd_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> wsm_ready);
endmodule

bind flash_wsm flash_wsm_chk #(.NBLK(NBLK), .BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pd_n(pd_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .wsm_ready(wsm_ready), .status(status), .blk_lock(blk_lock),
  .mst_lock(mst_lock), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/flash_wsm_tb.sv
module flash_wsm_tb;
  localparam int NB = 32, BB = 4, WR = 20, ER = 60, LK = 10, AW = 7;

  logic clk = 1'b0, rst = 1'b1, pd_n = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wsm_ready;

  always #5 clk = ~clk;

  flash_wsm #(.NBLK(NB), .BLK_BYTES(BB), .WR_CYC(WR), .ER_CYC(ER), .LK_CYC(LK)) u_dut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wsm_ready(wsm_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mm [1 << AW];

  function automatic logic [AW-1:0] baddr(int b, int o);
    return AW'(b * BB + o);
  endfunction

  function automatic logic [7:0] exp_stat(bit es, bit ws, bit pr, bit sq);
    return {1'b1, es, ws, pr, sq, 3'b000};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [AW-1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] q);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic rd_arr(logic [AW-1:0] a, output logic [7:0] q);
    cmd('0, 8'hFF);
    rd(a, q);
  endtask

  task automatic rd_stat(output logic [7:0] q);
    cmd('0, 8'h70);
    rd('0, q);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    @(negedge clk);
    while (!wsm_ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [7:0] d, output int n);
    cmd('0, 8'h40);
    cmd(a, d);
    wait_rdy(n);
  endtask

  task automatic do_erase(int b, output int n);
    cmd('0, 8'h20);
    cmd(baddr(b, 0), 8'hD0);
    wait_rdy(n);
  endtask

  task automatic do_lock(logic [AW-1:0] a, logic [7:0] sub, output int n);
    cmd('0, 8'h60);
    cmd(a, sub);
    wait_rdy(n);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] q;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R8 reset ready", wsm_ready, 1);
    rd_stat(q);
    chk("R8 reset status", q, 8'h80);

    // R2: erase every block, first one timed
    for (int b = 0; b < NB; b++) begin
      do_erase(b, n);
      if (b == 0) chk("R2 erase busy cycles", n, ER);
      for (int o = 0; o < BB; o++) mm[b * BB + o] = 8'hFF;
    end
    rd_arr(baddr(17, 3), q);
    chk("R2 erased byte", q, 8'hFF);

    // R1: timed program
    do_write(7'd9, 8'h3C, n);
    mm[9] = 8'h3C;
    chk("R1 program busy cycles", n, WR);
    rd_arr(7'd9, q);
    chk("R1 programmed byte", q, 8'h3C);

    // R1/R2 random mix against the model
    for (int i = 0; i < 150; i++) begin
      int op;
      op = $urandom % 8;
      if (op < 4) begin
        logic [AW-1:0] a;
        logic [7:0] d;
        a = AW'($urandom);
        d = 8'($urandom);
        do_write(a, d, n);
        mm[a] = d;
        chk("R1 random program busy", n, WR);
      end else if (op < 7) begin
        logic [AW-1:0] a;
        a = AW'($urandom);
        rd_arr(a, q);
        chk("R1 random readback", q, mm[a]);
      end else begin
        int b;
        b = $urandom % NB;
        do_erase(b, n);
        for (int o = 0; o < BB; o++) mm[b * BB + o] = 8'hFF;
        rd_arr(baddr(b, $urandom % BB), q);
        chk("R2 random erase", q, 8'hFF);
      end
    end

    // R9: bad confirm after erase setup
    cmd('0, 8'h20);
    cmd(baddr(1, 0), 8'h33);
    rd_stat(q);
    chk("R9 sequence error", q, exp_stat(0, 0, 0, 1));
    cmd('0, 8'h50);
    rd_stat(q);
    chk("R8 clear status", q, 8'h80);

    // R3: block lock refuses program and erase
    do_lock(baddr(5, 0), 8'h01, n);
    chk("R3 lock busy cycles", n, LK);
    do_write(baddr(5, 2), 8'h00, n);
    chk("R3 locked program not busy", n, 0);
    rd_stat(q);
    chk("R3 protection flag", q, exp_stat(0, 0, 1, 0));
    rd_stat(q);
    chk("R8 protection sticky", q, exp_stat(0, 0, 1, 0));
    do_erase(5, n);
    chk("R3 locked erase not busy", n, 0);
    rd_arr(baddr(5, 2), q);
    chk("R3 locked array unchanged", q, mm[baddr(5, 2)]);
    cmd('0, 8'h50);

    // R5: clear all lock bits
    do_lock('0, 8'hD0, n);
    chk("R5 clear locks busy", n, LK);
    do_write(baddr(5, 2), 8'h77, n);
    mm[baddr(5, 2)] = 8'h77;
    chk("R5 program after clear", n, WR);
    rd_arr(baddr(5, 2), q);
    chk("R5 unlocked readback", q, 8'h77);

    // R7: program suspend and resume
    cmd('0, 8'h40);
    cmd(7'd20, 8'h5E);
    repeat (3) @(negedge clk);
    cmd('0, 8'hB0);
    @(negedge clk);
    chk("R7 ready while suspended", wsm_ready, 1);
    rd_stat(q);
    chk("R7 suspend status", q, exp_stat(0, 1, 0, 0));
    rd_arr(7'd20, q);
    chk("R7 target unchanged while suspended", q, mm[20]);
    rd_arr(7'd9, q);
    chk("R7 read other location", q, mm[9]);
    cmd('0, 8'hD0);
    wait_rdy(n);
    chk("R7 remaining busy cycles", n, WR - 4);
    mm[20] = 8'h5E;
    rd_arr(7'd20, q);
    chk("R7 resumed program result", q, 8'h5E);

    // R6: erase suspend with program to another block
    do_write(baddr(7, 1), 8'h12, n);
    mm[baddr(7, 1)] = 8'h12;
    cmd('0, 8'h20);
    cmd(baddr(7, 0), 8'hD0);
    repeat (5) @(negedge clk);
    cmd('0, 8'hB0);
    @(negedge clk);
    chk("R6 ready while suspended", wsm_ready, 1);
    rd_stat(q);
    chk("R6 suspend status", q, exp_stat(1, 0, 0, 0));
    rd_arr(7'd20, q);
    chk("R6 read other block", q, mm[20]);
    do_write(baddr(9, 3), 8'hA5, n);
    mm[baddr(9, 3)] = 8'hA5;
    chk("R6 program during suspend busy", n, WR);
    rd_arr(baddr(9, 3), q);
    chk("R6 program during suspend data", q, 8'hA5);
    do_write(baddr(7, 2), 8'h00, n);
    rd_stat(q);
    chk("R6 program to suspended block refused", q, exp_stat(1, 0, 1, 0));
    cmd('0, 8'h50);
    cmd('0, 8'hD0);
    wait_rdy(n);
    chk("R6 remaining erase cycles", n, ER - 6);
    for (int o = 0; o < BB; o++) mm[baddr(7, o)] = 8'hFF;
    rd_arr(baddr(7, 1), q);
    chk("R6 resumed erase result", q, 8'hFF);

    // R4: master lock gates block lock changes
    do_lock(baddr(2, 0), 8'h01, n);
    do_lock('0, 8'hF1, n);
    chk("R4 master lock busy", n, LK);
    do_lock(baddr(3, 0), 8'h01, n);
    chk("R4 set block refused", n, 0);
    rd_stat(q);
    chk("R4 set block prot flag", q, exp_stat(0, 0, 1, 0));
    cmd('0, 8'h50);
    do_lock('0, 8'hD0, n);
    chk("R4 clear all refused", n, 0);
    cmd('0, 8'h50);
    do_write(baddr(3, 0), 8'h44, n);
    mm[baddr(3, 0)] = 8'h44;
    chk("R4 block 3 stays unlocked", n, WR);
    do_write(baddr(2, 0), 8'h00, n);
    chk("R4 block 2 stays locked", n, 0);
    cmd('0, 8'h50);

    // R10: power-down aborts and ignores writes
    do_write(baddr(10, 1), 8'h5A, n);
    mm[baddr(10, 1)] = 8'h5A;
    cmd('0, 8'h20);
    cmd(baddr(10, 0), 8'hD0);
    repeat (3) @(negedge clk);
    chk("R10 busy before power-down", wsm_ready, 0);
    pd_n = 1'b0;
    @(negedge clk);
    chk("R10 ready in power-down", wsm_ready, 1);
    cmd('0, 8'h40);
    cmd(baddr(11, 0), 8'h00);
    chk("R10 ready after ignored writes", wsm_ready, 1);
    pd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 ready after wake", wsm_ready, 1);
    rd_stat(q);
    chk("R10 status cleared", q, 8'h80);
    rd_arr(baddr(10, 1), q);
    chk("R10 aborted erase left data", q, 8'h5A);
    rd_arr(baddr(11, 0), q);
    chk("R10 ignored program", q, mm[baddr(11, 0)]);
    do_write(baddr(2, 1), 8'h00, n);
    chk("R10 lock bits kept", n, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule